// File: doc/BRIEF.md
# Reset Hold Duration Counter

This block measures how long an external active-low reset button or pin is held down. It counts cycles of the reference clock, nominally 25 MHz, so one count is 40 ns and one second is 25,000,000 counts. The pin is asynchronous. It passes through a synchronizer before it drives the counter. The count saturates at its top value instead of wrapping. It is kept when the pin is released, so software can read the hold time after the system comes back up.

Software uses a two-entry register port. Entry 0 is the length register: it returns the count, and writing it with bit 31 set clears the count. Entry 1 is a threshold register. A sticky long-press flag rises once the count reaches the threshold, and firmware can treat it as a factory-reset request. The flag is cleared together with the count.

Top module: `rst_hold_timer`

## Requirements
- R1: While the synchronized pin is low, the count rises by one per clock. A low level held for K clocks adds exactly K, after a two-flop synchronizer delay of two cycles.
- R2: While the pin is high the count holds its value. A later low period continues from the held value.
- R3: The count is CNT_W bits wide (default 29). At 2^CNT_W-1 it stays put while the pin remains low.
- R4: A read with regAddr=0 returns the count in bits [CNT_W-1:0]. All higher bits, including bit 31, read as zero.
- R5: A write with regAddr=0 and bit 31 set clears the count and the long-press flag on the next clock edge. It has priority over counting.
- R6: A write with regAddr=0 and bit 31 clear changes nothing.
- R7: A write with regAddr=1 loads the threshold from bits [CNT_W-1:0]. A read with regAddr=1 returns it, with the higher bits zero.
- R8: longPress rises one cycle after the count is at least the threshold. It then stays high until a clear as in R5.
- R9: After reset the count is 0, longPress is 0, and the threshold is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Block reset, active low, asynchronous |
| sysRstPinN | input | 1 | Monitored reset pin, active low, asynchronous |
| regAddr | input | 1 | Register select: 0 length, 1 threshold |
| regWrEn | input | 1 | Write strobe, one cycle |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| longPress | output | 1 | Sticky long-press flag |

## Verification
The assertions take for granted that regAddr and regWrData are stable and meaningful in any cycle where regWrEn is high. They also assume the pin reaches the counter only through the synchronizer output. The stimulus changes every input on the falling clock edge and pulses regWrEn for exactly one cycle. It holds the pin at each level for whole clock periods and gives the synchronizer and the flag register time to settle before each read. To make saturation reachable, the bench uses a 10-bit count. The random hold lengths and threshold values are kept small enough that most runs cross the threshold before they saturate.

// File: rtl/rht_pkg.sv
package rht_pkg;
  typedef struct packed {
    logic countEn;
    logic clearCnt;
    logic loadThresh;
  } rhtStrobes_t;

  localparam logic ADDR_LEN = 1'b0;
  localparam logic ADDR_THR = 1'b1;
endpackage

// File: rtl/rht_ctrl.sv
module rht_ctrl
  import rht_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinN,
  input  logic              regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output rhtStrobes_t       strobes
);
  localparam int CLR_BIT = DATA_W - 1;

  logic [SYNC_STAGES-1:0] syncChain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '1;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], pinN};
  end

  always_comb begin
    strobes.countEn    = ~syncChain[SYNC_STAGES-1];
    strobes.clearCnt   = regWrEn && (regAddr == ADDR_LEN) && regWrData[CLR_BIT];
    strobes.loadThresh = regWrEn && (regAddr == ADDR_THR);
  end
endmodule

// File: rtl/rht_datapath.sv
module rht_datapath
  import rht_pkg::*;
#(
  parameter int CNT_W  = 29,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  rhtStrobes_t       strobes,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [CNT_W-1:0]  cntValue,
  output logic              longPress
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] threshReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                       cntValue <= '0;
    else if (strobes.clearCnt)                       cntValue <= '0;
    else if (strobes.countEn && cntValue != CNT_MAX) cntValue <= cntValue + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    threshReg <= CNT_MAX;
    else if (strobes.loadThresh)  threshReg <= regWrData[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       longPress <= 1'b0;
    else if (strobes.clearCnt)       longPress <= 1'b0;
    else if (cntValue >= threshReg)  longPress <= 1'b1;
  end

  always_comb begin
    regRdData = '0;
    regRdData[CNT_W-1:0] = (regAddr == ADDR_THR) ? threshReg : cntValue;
  end
endmodule

// File: rtl/rst_hold_timer.sv
module rst_hold_timer
  import rht_pkg::*;
#(
  parameter int CNT_W       = 29,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysRstPinN,
  input  logic              regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              longPress
);
  rhtStrobes_t      strobes;
  logic [CNT_W-1:0] cntValue;

  rht_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .pinN(sysRstPinN), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .strobes(strobes)
  );

  rht_datapath #(.CNT_W(CNT_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cntValue(cntValue),
    .longPress(longPress)
  );
endmodule

// File: rtl/rht_checker.sv
module rht_checker
  import rht_pkg::*;
#(
  parameter int CNT_W  = 29,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input rhtStrobes_t       strobes,
  input logic [CNT_W-1:0]  cntValue,
  input logic              longPress,
  input logic              regAddr,
  input logic [DATA_W-1:0] regRdData
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  a_r1_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.countEn && !strobes.clearCnt && cntValue != CNT_MAX |=> cntValue == $past(cntValue) + 1'b1);

  a_r2_hold_released: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.countEn && !strobes.clearCnt |=> $stable(cntValue));

  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    cntValue == CNT_MAX && !strobes.clearCnt |=> cntValue == CNT_MAX);

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == ADDR_LEN |-> regRdData[DATA_W-1:CNT_W] == '0);

  a_r5_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearCnt |=> cntValue == '0 && !longPress);

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    longPress && !strobes.clearCnt |=> longPress);
endmodule

bind rst_hold_timer rht_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .strobes(strobes), .cntValue(cntValue),
  .longPress(longPress), .regAddr(regAddr), .regRdData(regRdData)
);

// File: tb/tb_rst_hold_timer.sv
module tb_rst_hold_timer;
  localparam int CW = 10;
  localparam int DW = 32;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 0, rstN = 0, pinN = 1, regAddr = 0, regWrEn = 0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] regRdData;
  logic longPress;

  int checks = 0, errors = 0;
  int mCnt = 0, mThr = MAXC;
  bit mFlag = 0;

  always #2.5 clk = ~clk;

  rst_hold_timer #(.CNT_W(CW), .DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .sysRstPinN(pinN), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .longPress(longPress)
  );

  function automatic int satAdd(int a, int b);
    return (a + b > MAXC) ? MAXC : a + b;
  endfunction

  function automatic bit nextFlag(bit f, int c, int t);
    return f | (c >= t);
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic readCheck(bit a, int exp, string req);
    regAddr = a;
    #1;
    check(req, regRdData, exp);
  endtask

  task automatic holdPin(int k);
    @(negedge clk); pinN = 0;
    repeat (k) @(negedge clk);
    pinN = 1;
    repeat (3) @(negedge clk);
    mCnt = satAdd(mCnt, k);
    mFlag = nextFlag(mFlag, mCnt, mThr);
  endtask

  task automatic writeReg(bit a, logic [DW-1:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk);
    regWrEn = 0; regWrData = '0;
    @(negedge clk);
    if (a == 1'b0 && d[DW-1]) begin mCnt = 0; mFlag = 0; end
    if (a == 1'b1) mThr = int'(d[CW-1:0]);
    mFlag = nextFlag(mFlag, mCnt, mThr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R9 reset state
    readCheck(0, 0, "R9 count");
    readCheck(1, MAXC, "R9 threshold");
    check("R9 flag", longPress, 0);

    // R1 single hold
    holdPin(7);
    readCheck(0, 7, "R1 count K");
    // R2 held then continued
    repeat (10) @(negedge clk);
    readCheck(0, 7, "R2 held after release");
    holdPin(5);
    readCheck(0, 12, "R2 continued");
    // R6 write without bit 31
    writeReg(0, 32'h7FFF_FFFF);
    readCheck(0, 12, "R6 no effect");
    // R7 threshold
    writeReg(1, 32'hFFFF_F014);
    readCheck(1, 20, "R7 threshold readback");
    check("R8 flag below threshold", longPress, 0);
    holdPin(8);
    check("R8 flag at threshold", longPress, 1);
    // R5 clear
    writeReg(0, 32'h8000_0000);
    readCheck(0, 0, "R5 count cleared");
    check("R5 flag cleared", longPress, 0);
    // R3 saturation
    holdPin(MAXC + 80);
    readCheck(0, MAXC, "R3 saturated");
    check("R4 upper bits zero", regRdData[DW-1:CW], 0);
    holdPin(5);
    readCheck(0, MAXC, "R3 stays at max");
    writeReg(0, 32'h8000_0000);

    // random mix
    for (int i = 0; i < 40; i++) begin
      int op = $urandom_range(3, 0);
      case (op)
        0, 1: holdPin($urandom_range(40, 1));
        2: writeReg(0, {($urandom_range(3, 0) == 0), 31'($urandom)});
        default: writeReg(1, 32'($urandom_range(200, 0)));
      endcase
      readCheck(0, mCnt, "R1 random count");
      check("R8 random flag", longPress, mFlag);
    end
    readCheck(1, mThr, "R7 random threshold");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule